// File: doc/BRIEF.md
# Serial-Loaded Three-Common LCD Segment Driver

This block produces the drive codes for a multiplexed LCD panel with three common electrodes and 68 segment electrodes, scanned at one-third duty with one-third bias. A host loads the display over a three-wire serial link made of an enable line, a shift clock and a data line. Each transfer carries a device address followed by the on/off bits for every segment and common pair and a port-mode bit. The block latches a complete, correctly addressed transfer into display memory when the enable line drops. The system clock samples the serial lines, so they must already be synchronous to it and change slowly relative to it.

An oscillator tick input steps a scan divider. A frame is three common phases long, and the drive polarity flips every frame so the panel sees no DC component. Every common and segment output is a 2-bit level code for an external analog stage: 0 = ground, 1 = one-third, 2 = two-thirds, 3 = full bias. The first four segment pins can act as plain on/off outputs. A display-enable input blanks everything while serial loading continues.

Top module: `lcd3_drv`

## Requirements
- R1: While `rst` is high, every common and segment code is 0 and display memory is cleared. With cleared memory, the first frame shows every segment off.
- R2: A common phase lasts exactly 128 oscillator ticks. The selected common goes in the order common 0, common 1, common 2 and then wraps.
- R3: In a positive frame the selected common is code 3 and the other commons are code 1. In a negative frame the selected common is code 0 and the others are code 2.
- R4: Polarity starts positive after reset and flips after every 384 oscillator ticks (one full frame).
- R5: An "on" segment is driven to the code opposite the selected common (0 when positive, 3 when negative). An "off" segment is driven to 2 when positive and 1 when negative. The on/off bit used is the one stored for the currently selected common.
- R6: A transfer starts when `ser_en` rises. Data is sampled on each rising edge of `ser_clk` while `ser_en` is high. The first 8 bits are the address, MSB first. The next 204 bits are the display bits: bit 3*p+c is pin p (0-based) under common c. The 213th bit is the port-mode bit. The falling edge of `ser_en` copies all of these into display memory.
- R7: A transfer whose address differs from `DEV_ADDR` (default 0x5C) leaves display memory unchanged.
- R8: A transfer shorter than 213 bits leaves display memory unchanged. Bits beyond the 213th are ignored.
- R9: With port mode set, pins 0 to 3 output code 3 if their common-0 bit is 1 and code 0 otherwise, in every phase and frame.
- R10: While `disp_on` is low, every common and segment code is 0 and port mode has no effect.
- R11: Transfers received while `disp_on` is low are latched normally and appear once `disp_on` returns high.
- R12: Outputs are registered: each code reflects the scan state, memory and `disp_on` sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| ser_en | input | 1 | Serial transfer enable |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_dat | input | 1 | Serial data |
| disp_on | input | 1 | High shows the display, low blanks it |
| com_lvl | output | 6 | Level code of common c at bits [2c+1:2c] |
| seg_lvl | output | 136 | Level code of pin p at bits [2p+1:2p] |

## Verification
A stuck or mis-stepped scan counter shows on the common codes within a phase of 128 ticks. A wrong polarity register shows within one frame, because the codes for one polarity are disjoint from those of the other. A corrupted display memory bit or a wrongly accepted transfer changes a segment code within one clock of the selected phase reaching that bit. The bench therefore compares every output against a behavioural model on every clock, and measures phase and frame lengths in ticks.

// File: rtl/lcd3_pkg.sv
package lcd3_pkg;

  typedef enum logic [1:0] {
    LVL_GND   = 2'd0,
    LVL_THIRD = 2'd1,
    LVL_TWO3  = 2'd2,
    LVL_FULL  = 2'd3
  } lvl_e;

  // Common drive level: selected common sits at the rail, others at near bias
  function automatic lvl_e com_code(input logic sel, input logic neg);
    if (sel) return neg ? LVL_GND : LVL_FULL;
    return neg ? LVL_TWO3 : LVL_THIRD;
  endfunction

  // Segment drive level: "on" opposes the selected common, "off" sits mid-way
  function automatic lvl_e seg_code(input logic on, input logic neg);
    if (on) return neg ? LVL_FULL : LVL_GND;
    return neg ? LVL_THIRD : LVL_TWO3;
  endfunction

endpackage

// File: rtl/lcd3_scan.sv
module lcd3_scan #(
  parameter int N_COM     = 3,
  parameter int PHASE_LEN = 128,
  localparam int PH_W     = (N_COM > 1) ? $clog2(N_COM) : 1,
  localparam int TK_W     = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            osc_tick,
  output logic [PH_W-1:0] phase,
  output logic            neg
);

  logic [TK_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      phase    <= '0;
      neg      <= 1'b0;
    end else if (osc_tick) begin
      if (tick_cnt == TK_W'(PHASE_LEN - 1)) begin
        tick_cnt <= '0;
        if (phase == PH_W'(N_COM - 1)) begin
          phase <= '0;
          neg   <= ~neg;
        end else begin
          phase <= phase + 1'b1;
        end
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd3_serial_rx.sv
module lcd3_serial_rx #(
  parameter int              N_COM    = 3,
  parameter int              N_SEG    = 68,
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h5C,
  localparam int MEM_BITS   = N_SEG * N_COM,
  localparam int PAY_BITS   = MEM_BITS + 1,
  localparam int FRAME_BITS = ADDR_W + PAY_BITS,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_en,
  input  logic                ser_clk,
  input  logic                ser_dat,
  output logic [MEM_BITS-1:0] lat_bits,
  output logic                lat_pm
);

  logic              en_q, sclk_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [PAY_BITS-1:0] pay;
  logic              start_xfer, shift_bit, end_xfer, accept;

  assign start_xfer = ser_en & ~en_q;
  assign shift_bit  = ser_en & ser_clk & ~sclk_q & (bit_cnt != CNT_W'(FRAME_BITS));
  assign end_xfer   = ~ser_en & en_q;
  assign accept     = end_xfer & (bit_cnt == CNT_W'(FRAME_BITS)) & (addr_sh == DEV_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      sclk_q  <= 1'b0;
      bit_cnt <= '0;
      addr_sh <= '0;
    end else begin
      en_q   <= ser_en;
      sclk_q <= ser_clk;
      if (start_xfer) begin
        bit_cnt <= '0;
      end else if (shift_bit) begin
        if (bit_cnt < CNT_W'(ADDR_W)) addr_sh <= {addr_sh[ADDR_W-2:0], ser_dat};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // Payload staging: no reset needed, only copied after a full frame
  always_ff @(posedge clk) begin
    if (!rst && !start_xfer && shift_bit && bit_cnt >= CNT_W'(ADDR_W))
      pay[bit_cnt - CNT_W'(ADDR_W)] <= ser_dat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_bits <= '0;
      lat_pm   <= 1'b0;
    end else if (accept) begin
      lat_bits <= pay[MEM_BITS-1:0];
      lat_pm   <= pay[PAY_BITS-1];
    end
  end

endmodule

// File: rtl/lcd3_drive.sv
module lcd3_drive
  import lcd3_pkg::*;
#(
  parameter int N_COM  = 3,
  parameter int N_SEG  = 68,
  parameter int N_PORT = 4,
  localparam int PH_W  = (N_COM > 1) ? $clog2(N_COM) : 1,
  localparam int MEM_BITS = N_SEG * N_COM
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 disp_on,
  input  logic [PH_W-1:0]      phase,
  input  logic                 neg,
  input  logic [MEM_BITS-1:0]  lat_bits,
  input  logic                 lat_pm,
  output logic [2*N_COM-1:0]   com_lvl,
  output logic [2*N_SEG-1:0]   seg_lvl
);

  logic [2*N_COM-1:0] com_nx;
  logic [2*N_SEG-1:0] seg_nx;

  for (genvar c = 0; c < N_COM; c++) begin : g_com
    assign com_nx[2*c +: 2] = disp_on ? com_code(phase == PH_W'(c), neg) : LVL_GND;
  end

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    logic [N_COM-1:0] cells;
    logic             on;
    assign cells = lat_bits[s*N_COM +: N_COM];
    assign on    = cells[phase];
    if (s < N_PORT) begin : g_port
      // Dual-use pin: plain output in port mode, otherwise a segment
      assign seg_nx[2*s +: 2] = !disp_on ? LVL_GND :
                                lat_pm   ? (cells[0] ? LVL_FULL : LVL_GND) :
                                           seg_code(on, neg);
    end else begin : g_plain
      assign seg_nx[2*s +: 2] = disp_on ? seg_code(on, neg) : LVL_GND;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl <= '0;
      seg_lvl <= '0;
    end else begin
      com_lvl <= com_nx;
      seg_lvl <= seg_nx;
    end
  end

endmodule

// File: rtl/lcd3_drv.sv
module lcd3_drv #(
  parameter int              N_COM     = 3,
  parameter int              N_SEG     = 68,
  parameter int              N_PORT    = 4,
  parameter int              PHASE_LEN = 128,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h5C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               osc_tick,
  input  logic               ser_en,
  input  logic               ser_clk,
  input  logic               ser_dat,
  input  logic               disp_on,
  output logic [2*N_COM-1:0] com_lvl,
  output logic [2*N_SEG-1:0] seg_lvl
);

  localparam int PH_W     = (N_COM > 1) ? $clog2(N_COM) : 1;
  localparam int MEM_BITS = N_SEG * N_COM;

  logic [PH_W-1:0]     phase;
  logic                neg;
  logic [MEM_BITS-1:0] lat_bits;
  logic                lat_pm;

  lcd3_scan #(.N_COM(N_COM), .PHASE_LEN(PHASE_LEN)) scan_i (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .phase(phase), .neg(neg)
  );

  lcd3_serial_rx #(.N_COM(N_COM), .N_SEG(N_SEG), .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) rx_i (
    .clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .lat_bits(lat_bits), .lat_pm(lat_pm)
  );

  lcd3_drive #(.N_COM(N_COM), .N_SEG(N_SEG), .N_PORT(N_PORT)) drive_i (
    .clk(clk), .rst(rst), .disp_on(disp_on), .phase(phase), .neg(neg),
    .lat_bits(lat_bits), .lat_pm(lat_pm), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

endmodule

// File: rtl/lcd3_drv_chk.sv
module lcd3_drv_chk #(
  parameter int N_COM  = 3,
  parameter int N_SEG  = 68,
  parameter int N_PORT = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     disp_on,
  input logic                     ser_en,
  input logic [2*N_COM-1:0]       com_lvl,
  input logic [2*N_SEG-1:0]       seg_lvl,
  input logic [N_SEG*N_COM-1:0]   lat_bits,
  input logic                     lat_pm
);

  logic [N_COM-1:0] at_rail;
  logic             has_full, has_gnd, even_ok, odd_ok, port_ok, all_low;

  always_comb begin
    has_full = 1'b0;
    has_gnd  = 1'b0;
    for (int c = 0; c < N_COM; c++) begin
      at_rail[c] = (com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3);
      if (com_lvl[2*c +: 2] == 2'd3) has_full = 1'b1;
      if (com_lvl[2*c +: 2] == 2'd0) has_gnd  = 1'b1;
    end
    even_ok = 1'b1;
    odd_ok  = 1'b1;
    for (int s = N_PORT; s < N_SEG; s++) begin
      if (seg_lvl[2*s])  even_ok = 1'b0;
      if (!seg_lvl[2*s]) odd_ok  = 1'b0;
    end
    port_ok = 1'b1;
    for (int s = 0; s < N_PORT; s++)
      if (seg_lvl[2*s] != seg_lvl[2*s+1]) port_ok = 1'b0;
    all_low = (com_lvl == '0) && (seg_lvl == '0);
  end

  AST_INHIBIT_LOW: assert property (@(posedge clk) disable iff (rst)
    !$past(disp_on) |-> all_low);  // R10

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    ($past(disp_on) && !$past(rst)) |-> ($countones(at_rail) == 1));  // R3

  AST_SEG_BIAS_POS: assert property (@(posedge clk) disable iff (rst)
    ($past(disp_on) && !$past(rst) && has_full) |-> even_ok);  // R5

  AST_SEG_BIAS_NEG: assert property (@(posedge clk) disable iff (rst)
    ($past(disp_on) && !$past(rst) && has_gnd) |-> odd_ok);  // R5

  AST_LATCH_ON_CE_FALL: assert property (@(posedge clk) disable iff (rst)
    !($stable(lat_bits) && $stable(lat_pm)) |-> (!$past(ser_en) && $past(ser_en, 2)));  // R6

  AST_PORT_LEVELS: assert property (@(posedge clk) disable iff (rst)
    ($past(lat_pm) && $past(disp_on) && !$past(rst)) |-> port_ok);  // R9

endmodule

bind lcd3_drv lcd3_drv_chk #(.N_COM(N_COM), .N_SEG(N_SEG), .N_PORT(N_PORT)) chk_i (
  .clk(clk), .rst(rst), .disp_on(disp_on), .ser_en(ser_en),
  .com_lvl(com_lvl), .seg_lvl(seg_lvl), .lat_bits(lat_bits), .lat_pm(lat_pm)
);

// File: tb/lcd3_drv_tb.sv
module lcd3_drv_tb_top;

  localparam int NC = 3;
  localparam int NS = 68;
  localparam int NB = NS * NC;
  localparam int FB = 8 + NB + 1;
  localparam logic [7:0] ADDR = 8'h5C;

  logic clk = 1'b0, rst = 1'b1, osc_tick = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, disp_on = 1'b1;
  logic [2*NC-1:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;

  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  lcd3_drv dut_i (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .disp_on(disp_on), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // oscillator tick: one pulse every third clock
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    osc_tick = (tdiv == 0);
  end

  // ---------------- behavioural reference model ----------------
  int m_tick, m_phase, m_cnt;
  bit m_neg, m_pce, m_pcl, m_pm, cmp_on;
  bit [7:0] m_addr;
  bit m_sh[FB-8];
  bit m_lat[NB];
  logic [2*NC-1:0] e_com;
  logic [2*NS-1:0] e_seg;

  function automatic logic [1:0] seg_exp(bit on, bit neg);
    return on ? (neg ? 2'd3 : 2'd0) : (neg ? 2'd1 : 2'd2);
  endfunction

  always @(posedge clk) begin
    cmp_on = 1'b1;
    if (rst) begin
      m_tick = 0; m_phase = 0; m_neg = 0; m_cnt = 0; m_addr = 0;
      m_pce = 0; m_pcl = 0; m_pm = 0;
      foreach (m_lat[k]) m_lat[k] = 0;
      e_com = '0; e_seg = '0;
    end else begin
      for (int c = 0; c < NC; c++)
        e_com[2*c +: 2] = !disp_on ? 2'd0 : (c == m_phase) ? (m_neg ? 2'd0 : 2'd3)
                                                            : (m_neg ? 2'd2 : 2'd1);
      for (int p = 0; p < NS; p++)
        if (!disp_on)          e_seg[2*p +: 2] = 2'd0;
        else if (m_pm && p < 4) e_seg[2*p +: 2] = m_lat[3*p] ? 2'd3 : 2'd0;
        else                    e_seg[2*p +: 2] = seg_exp(m_lat[3*p + m_phase], m_neg);
      if (ser_en && !m_pce) m_cnt = 0;
      else if (ser_en && ser_clk && !m_pcl && m_cnt < FB) begin
        if (m_cnt < 8) m_addr = {m_addr[6:0], ser_dat};
        else m_sh[m_cnt-8] = ser_dat;
        m_cnt++;
      end
      if (!ser_en && m_pce && m_cnt == FB && m_addr == ADDR) begin
        for (int k = 0; k < NB; k++) m_lat[k] = m_sh[k];
        m_pm = m_sh[NB];
      end
      m_pce = ser_en; m_pcl = ser_clk;
      if (osc_tick) begin
        m_tick++;
        if (m_tick == 128) begin
          m_tick = 0; m_phase++;
          if (m_phase == 3) begin m_phase = 0; m_neg = !m_neg; end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [2*NS-1:0] act, input logic [2*NS-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2 R3 R4 R12 per-clock commons", {130'd0, com_lvl}, {130'd0, e_com});
    chk("R5 R6 R9 R10 R11 R12 per-clock segments", seg_lvl, e_seg);
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [NB-1:0] mkpat(int seed);
    logic [NB-1:0] v;
    for (int k = 0; k < NB; k++) v[k] = (((k * seed) + (k / 3)) % 5) < 2;
    return v;
  endfunction

  task automatic send_frame(input logic [7:0] a, input logic [NB-1:0] p, input bit pm, input int nbits);
    @(negedge clk) ser_en = 1'b1;
    repeat (2) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      ser_dat = (b < 8) ? a[7-b] : (b < 8 + NB) ? p[b-8] : (b == 8 + NB) ? pm : 1'b1;
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (2) @(negedge clk);
    end
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
    ser_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit is_sel(int c, bit neg);
    return com_lvl[2*c +: 2] == (neg ? 2'd0 : 2'd3);
  endfunction

  task automatic wait_sel(input int c, input bit neg);
    do @(negedge clk); while (!is_sel(c, neg));
  endtask

  task automatic chk_pattern(input string tag, input logic [NB-1:0] p, input bit pm, input int c, input bit neg);
    logic [2*NS-1:0] e;
    wait_sel(c, neg);
    for (int q = 0; q < NS; q++)
      e[2*q +: 2] = (pm && q < 4) ? (p[3*q] ? 2'd3 : 2'd0) : seg_exp(p[3*q + c], neg);
    chk(tag, seg_lvl, e);
  endtask

  task automatic measure(input int c0, input bit n0, input int c1, input bit n1, output int n);
    bit prev = 1'b1, now;
    forever begin
      @(negedge clk);
      now = is_sel(c0, n0);
      if (now && !prev) break;
      prev = now;
    end
    n = 0;
    forever begin
      @(posedge clk);
      if (osc_tick) n++;
      @(negedge clk);
      if (is_sel(c1, n1)) break;
    end
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [NB-1:0] pa, pb, pc, pd;
    int n;
    pa = mkpat(7); pb = mkpat(11); pc = mkpat(13); pd = mkpat(17);
    repeat (3) @(negedge clk);
    chk("R1 reset commons", {130'd0, com_lvl}, '0);
    chk("R1 reset segments", seg_lvl, '0);
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 cleared memory shows all off", seg_lvl, {NS{2'd2}});

    wait_sel(0, 0);
    chk("R3 positive common levels", {130'd0, com_lvl}, {130'd0, 6'b01_01_11});
    measure(0, 0, 1, 0, n);
    chk("R2 phase length in ticks", 136'(n), 136'd128);
    measure(0, 0, 0, 1, n);
    chk("R4 frame length to polarity flip", 136'(n), 136'd384);
    chk("R3 negative common levels", {130'd0, com_lvl}, {130'd0, 6'b10_10_00});

    send_frame(ADDR, pa, 1'b0, FB);
    chk_pattern("R6 pattern A common0 pos", pa, 0, 0, 0);
    chk_pattern("R5 pattern A common1 pos", pa, 0, 1, 0);
    chk_pattern("R5 pattern A common2 neg", pa, 0, 2, 1);

    send_frame(8'h5D, pb, 1'b0, FB);
    chk_pattern("R7 wrong address keeps A", pa, 0, 0, 0);
    send_frame(ADDR, pb, 1'b0, FB - 1);
    chk_pattern("R8 short transfer keeps A", pa, 0, 1, 0);
    send_frame(ADDR, pb, 1'b0, FB + 5);
    chk_pattern("R8 long transfer takes B", pb, 0, 2, 0);

    send_frame(ADDR, pc, 1'b1, FB);
    chk_pattern("R9 port mode pos frame", pc, 1, 1, 0);
    chk_pattern("R9 port mode neg frame", pc, 1, 2, 1);

    @(negedge clk) disp_on = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 inhibit commons low", {130'd0, com_lvl}, '0);
    chk("R10 inhibit segments and ports low", seg_lvl, '0);
    send_frame(ADDR, pd, 1'b0, FB);
    chk("R11 still blank after load", seg_lvl, '0);
    @(negedge clk) disp_on = 1'b1;
    chk_pattern("R11 pattern D after release", pd, 0, 0, 1);
    chk_pattern("R11 pattern D next phase", pd, 0, 1, 1);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule